// File: doc/BRIEF.md
# Two-Write WOM Codec

This block stores a 2-bit value in three binary write-once cells so that the cells can be written a second time without an erase. A cell can only move from 0 to 1. The first write uses patterns that set at most one cell. The second write uses the bitwise complement of those patterns. Because of this choice, any new value can follow any first-write state by setting cells only. Across the two writes the code carries 4 bits in 3 cells, a sum-rate of 4/3.

The codec core is combinational. The encoder takes the message, the write index and the present cell state, and returns the state to program and an error flag. The decoder turns any of the eight cell states into the stored message.

A registered cell model wraps the same encoder around a 3-bit state register and a write counter. A caller can then stream writes into it and read the stored value back. The write port is a valid/ready pair. The model never applies back-pressure: `wr_ready` is high whenever reset is released, so every clock edge with `wr_valid` high is an accepted write.

Top module: `wom2_codec`

## Requirements
- R1: A first write (write index 0) onto state 000 yields message 00→000, 01→001, 10→010, 11→100, with no error.
- R2: Whenever the encoder reports no error, no cell that is 1 in the input state is 0 in the output state. The modelled cell register never clears a bit between resets.
- R3: A second write (write index 1) whose message differs from the decoded input state yields the complement pattern 00→111, 01→110, 10→101, 11→011.
- R4: A second write whose message equals the decoded input state returns the input state unchanged, with no error.
- R5: The decoder maps states of weight 0 or 1 as 000→00, 001→01, 010→10, 100→11. It maps states of weight 2 or 3 as 111→00, 110→01, 101→10, 011→11.
- R6: When the candidate pattern would clear a set cell, the error flag is 1 and the output state equals the input state.
- R7: A write index of 2 or 3 (a third or later write) raises the error flag and returns the input state unchanged.
- R8: After reset the model holds state 000 and a write count of 0, and `wr_err` is 0. Each accepted write programs the encoder's result, using the count as the write index, and `cell_msg` reports the decoded register.
- R9: In the model, a third accepted write sets `wr_err` for the following cycle and leaves `cell_state` unchanged. `wr_ready` stays high out of reset.
- R10: For every ordered pair of messages written into the model, `cell_msg` after each write equals the message just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell model |
| rst_n | input | 1 | Active-low synchronous reset of the cell model |
| enc_msg | input | 2 | Message to encode |
| enc_wnum | input | 2 | Write index: 0 first, 1 second, 2 or 3 illegal |
| enc_state_in | input | 3 | Present cell state seen by the encoder |
| enc_state_out | output | 3 | Cell state to program |
| enc_err | output | 1 | Encoding refused (clear needed or third write) |
| dec_state_in | input | 3 | Cell state to decode |
| dec_msg | output | 2 | Decoded message |
| wr_valid | input | 1 | Write beat offered to the cell model |
| wr_ready | output | 1 | Model accepts a beat (high out of reset) |
| wr_msg | input | 2 | Message carried by the write beat |
| cell_state | output | 3 | Modelled cell register |
| cell_msg | output | 2 | Decoded value of the cell register |
| wr_err | output | 1 | Registered error of the last accepted beat |

## Verification
The hardest case to reach is a write index of 1 applied to a state that a legal first write could never produce. Examples are a weight-2 state, or the case where a stored-message match has to be found on a second-layer pattern. The cell model never produces these states. The stimulus therefore drives the combinational encoder directly, sweeping all 8 states, 4 messages and 4 write indices. The model is then driven with all 16 ordered message pairs, each followed by a third beat, with a reset between sequences.

// File: rtl/wom2_pkg.sv
package wom2_pkg;
  localparam int CELLS  = 3;
  localparam int MSG_W  = 2;
  localparam int WNUM_W = 2;
  localparam int CNT_W  = 2;

  typedef logic [CELLS-1:0]  cells_t;
  typedef logic [MSG_W-1:0]  msg_t;
  typedef logic [WNUM_W-1:0] wnum_t;

  typedef enum logic [WNUM_W-1:0] {
    WR_FIRST  = 2'd0,
    WR_SECOND = 2'd1,
    WR_THIRD  = 2'd2
  } write_idx_e;

  // Light pattern: 0 -> none set, k -> cell k-1 set.
  function automatic cells_t light_pattern(input msg_t m);
    cells_t p;
    p = '0;
    if (m != '0) p = cells_t'(1) << (m - msg_t'(1));
    return p;
  endfunction
endpackage

// File: rtl/wom2_decoder.sv
module wom2_decoder
  import wom2_pkg::*;
(
  input  cells_t state_i,
  output msg_t   msg_o,
  output logic   heavy_o
);
  localparam int WGT_W = $clog2(CELLS + 1);
  logic [WGT_W-1:0] weight;
  cells_t           base;

  always_comb begin
    weight = '0;
    for (int i = 0; i < CELLS; i++) weight = weight + WGT_W'(state_i[i]);
  end

  assign heavy_o = (weight >= WGT_W'(2));
  assign base    = heavy_o ? ~state_i : state_i;

  always_comb begin
    msg_o = '0;
    for (int i = 0; i < CELLS; i++)
      if (base[i]) msg_o = msg_t'(i + 1);
  end
endmodule

// File: rtl/wom2_encoder.sv
module wom2_encoder
  import wom2_pkg::*;
(
  input  msg_t   msg_i,
  input  wnum_t  wnum_i,
  input  cells_t state_i,
  output cells_t state_o,
  output logic   err_o
);
  msg_t   stored;
  logic   heavy_unused;
  cells_t cand;
  logic   clears;
  logic   late;

  wom2_decoder u_cur_dec (
    .state_i (state_i),
    .msg_o   (stored),
    .heavy_o (heavy_unused)
  );

  always_comb begin
    unique case (wnum_i)
      WR_FIRST:  cand = light_pattern(msg_i);
      WR_SECOND: cand = (stored == msg_i) ? state_i : ~light_pattern(msg_i);
      default:   cand = state_i;
    endcase
  end

  assign late    = (wnum_i >= wnum_t'(WR_THIRD));
  assign clears  = |(state_i & ~cand);
  assign err_o   = late | clears;
  assign state_o = err_o ? state_i : cand;
endmodule

// File: rtl/wom2_cell_model.sv
module wom2_cell_model
  import wom2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  output logic             ready_o,
  input  msg_t             msg_i,
  output cells_t           state_o,
  output msg_t             msg_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WR_THIRD);

  cells_t           state_q;
  logic [CNT_W-1:0] count_q;
  logic             err_q;
  cells_t           next_state;
  logic             next_err;
  logic             heavy_unused;
  logic             take;

  assign ready_o = rst_n;
  assign take    = valid_i & ready_o;

  wom2_encoder u_enc (
    .msg_i   (msg_i),
    .wnum_i  (wnum_t'(count_q)),
    .state_i (state_q),
    .state_o (next_state),
    .err_o   (next_err)
  );

  wom2_decoder u_dec (
    .state_i (state_q),
    .msg_o   (msg_o),
    .heavy_o (heavy_unused)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take & next_err;
      if (take) begin
        state_q <= next_state;
        if (count_q != CNT_SAT) count_q <= count_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
  assign count_o = count_q;
endmodule

// File: rtl/wom2_codec.sv
module wom2_codec
  import wom2_pkg::*;
#(
  parameter bit MODEL_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] enc_msg,
  input  logic [1:0] enc_wnum,
  input  logic [2:0] enc_state_in,
  output logic [2:0] enc_state_out,
  output logic       enc_err,
  input  logic [2:0] dec_state_in,
  output logic [1:0] dec_msg,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [1:0] wr_msg,
  output logic [2:0] cell_state,
  output logic [1:0] cell_msg,
  output logic       wr_err
);
  logic             dec_heavy_unused;
  logic [CNT_W-1:0] wr_count;

  wom2_encoder u_enc (
    .msg_i   (enc_msg),
    .wnum_i  (enc_wnum),
    .state_i (enc_state_in),
    .state_o (enc_state_out),
    .err_o   (enc_err)
  );

  wom2_decoder u_dec (
    .state_i (dec_state_in),
    .msg_o   (dec_msg),
    .heavy_o (dec_heavy_unused)
  );

  generate
    if (MODEL_EN) begin : g_model
      wom2_cell_model u_model (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (wr_valid),
        .ready_o (wr_ready),
        .msg_i   (wr_msg),
        .state_o (cell_state),
        .msg_o   (cell_msg),
        .err_o   (wr_err),
        .count_o (wr_count)
      );
    end else begin : g_no_model
      assign wr_ready   = 1'b0;
      assign cell_state = '0;
      assign cell_msg   = '0;
      assign wr_err     = 1'b0;
      assign wr_count   = '0;
    end
  endgenerate
endmodule

// File: rtl/wom2_codec_chk.sv
module wom2_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] enc_msg,
  input logic [1:0] enc_wnum,
  input logic [2:0] enc_state_in,
  input logic [2:0] enc_state_out,
  input logic       enc_err,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] wr_msg,
  input logic [2:0] cell_state,
  input logic [1:0] cell_msg,
  input logic       wr_err,
  input logic [1:0] wr_count
);
  AST_ENC_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_err |-> ((enc_state_in & ~enc_state_out) == 3'b000)); // R2

  AST_CELL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cell_state) & ~cell_state) == 3'b000)); // R2

  AST_FIRST_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_wnum == 2'd0 && !enc_err) |-> ($countones(enc_state_out) <= 1)); // R1

  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err |-> (enc_state_out == enc_state_in)); // R6

  AST_LATE_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_wnum[1]) |-> enc_err); // R7

  AST_MODEL_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_count != 2'd2) |=> (cell_msg == $past(wr_msg) && !wr_err)); // R10

  AST_THIRD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_count == 2'd2) |=> (wr_err && $stable(cell_state))); // R9
endmodule

bind wom2_codec wom2_codec_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_msg       (enc_msg),
  .enc_wnum      (enc_wnum),
  .enc_state_in  (enc_state_in),
  .enc_state_out (enc_state_out),
  .enc_err       (enc_err),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_msg        (wr_msg),
  .cell_state    (cell_state),
  .cell_msg      (cell_msg),
  .wr_err        (wr_err),
  .wr_count      (wr_count)
);

// File: tb/wom2_codec_test.sv
`timescale 1ns/1ps
module wom2_codec_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] enc_msg = '0;
  logic [1:0] enc_wnum = '0;
  logic [2:0] enc_state_in = '0;
  logic [2:0] enc_state_out;
  logic       enc_err;
  logic [2:0] dec_state_in = '0;
  logic [1:0] dec_msg;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_msg = '0;
  logic [2:0] cell_state;
  logic [1:0] cell_msg;
  logic       wr_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wom2_codec uut (.*);

  function automatic logic [2:0] lite(input logic [1:0] m);
    return (m == 2'd0) ? 3'd0 : 3'(1 << (m - 1));
  endfunction

  function automatic logic [1:0] exp_dec(input logic [2:0] s);
    logic [2:0] b;
    int w;
    w = s[0] + s[1] + s[2];
    b = (w >= 2) ? ~s : s;
    return (b == 3'b001) ? 2'd1 : (b == 3'b010) ? 2'd2 : (b == 3'b100) ? 2'd3 : 2'd0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic beat(input logic [1:0] m);
    @(negedge clk); wr_valid = 1'b1; wr_msg = m;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R8 reset state
    check("R8 state", cell_state, 0);
    check("R8 err", wr_err, 0);
    check("R9 ready", wr_ready, 1);

    // R5 decoder sweep
    for (int s = 0; s < 8; s++) begin
      dec_state_in = 3'(s); #1;
      check("R5 decode", dec_msg, exp_dec(3'(s)));
    end

    // Encoder sweep: R1 R2 R3 R4 R6 R7
    for (int wn = 0; wn < 4; wn++)
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 4; m++) begin
          logic [2:0] cand, eo;
          logic ee;
          enc_wnum = 2'(wn); enc_state_in = 3'(s); enc_msg = 2'(m);
          #1;
          if (wn == 0) cand = lite(2'(m));
          else if (wn == 1) cand = (exp_dec(3'(s)) == 2'(m)) ? 3'(s) : ~lite(2'(m));
          else cand = 3'(s);
          ee = (wn >= 2) || ((3'(s) & ~cand) != 0);
          eo = ee ? 3'(s) : cand;
          if (wn >= 2) check("R7 err", enc_err, 1);
          else if (ee) check("R6 err", enc_err, 1);
          else if (wn == 0) check("R1 err", enc_err, 0);
          else check("R4 err", enc_err, 0);
          if (wn == 0 && s == 0) check("R1 state", enc_state_out, eo);
          else if (wn == 1 && exp_dec(3'(s)) == 2'(m)) check("R4 state", enc_state_out, eo);
          else if (wn == 1) check("R3 state", enc_state_out, eo);
          else check("R6 state", enc_state_out, eo);
          if (!enc_err) check("R2 no clear", int'(enc_state_in & ~enc_state_out), 0);
        end

    // Model: all ordered message pairs, then a third write
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        logic [2:0] s1, s2;
        do_reset();
        beat(2'(a));
        s1 = lite(2'(a));
        check("R8 first state", cell_state, s1);
        check("R10 first msg", cell_msg, a);
        check("R8 first err", wr_err, 0);
        beat(2'(b));
        s2 = (a == b) ? s1 : ~lite(2'(b));
        check("R10 second state", cell_state, s2);
        check("R10 second msg", cell_msg, b);
        check("R2 model keep", int'(s1 & ~cell_state), 0);
        beat(2'((b + 1) % 4));
        check("R9 third err", wr_err, 1);
        check("R9 third state", cell_state, s2);
        check("R9 ready", wr_ready, 1);
        @(negedge clk);
        check("R8 err clears", wr_err, 0);
      end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule